// File: doc/BRIEF.md
# Local interrupt priority arbiter

This block keeps the interrupt state of one processor for 256 vectors. Each vector has three state bits: requested, in service, and level-triggered. A requester raises a vector through the set port and gives its trigger kind with it. The core sees a registered pending flag. When the core acknowledges, the arbiter moves the winning vector from requested to in service and returns it. If the winner is masked, the arbiter returns a programmable spurious vector. If nothing can be returned, it reports that no vector was given.

Priority works on classes, where a class is the upper four bits of a vector. Software writes a task priority. The processor priority is the larger of two values: the task priority, and the class of the highest in-service vector. A requested vector is masked when the processor priority is nonzero and the vector's class does not exceed the processor priority's class.

An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, the block announces its completion on a broadcast output, unless the suppression input is set.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After a synchronous reset, all three bitmaps and the task priority are zero. `irq_pending`, `ack_kind`, `ack_vector`, `bcast_valid`, `bcast_vector` and `ppr` all read zero.
- R2: A set of vector V marks V as requested. It records V as level-triggered when `set_level` is 1 and as edge-triggered when `set_level` is 0. Only level-triggered vectors produce a broadcast at end of interrupt.
- R3: `ppr` equals the task priority when the task priority's upper nibble is at least the class of the highest in-service vector. Otherwise it equals that class shifted left by four. An empty in-service map counts as class 0.
- R4: An acknowledge picks the highest-numbered requested vector.
- R5: The winner is masked when `ppr` is nonzero and the winner's upper nibble is less than or equal to `ppr[7:4]`. Acknowledging a masked winner returns `ack_kind`=2 with `ack_vector`=`spurious_vector`, and leaves both bitmaps unchanged.
- R6: While `sw_enable` is 0, `irq_pending` stays 0 and every acknowledge returns `ack_kind`=0.
- R7: A granted acknowledge clears the vector's requested bit and sets its in-service bit. One cycle after `ack_req`, it presents `ack_kind`=1 with the vector on `ack_vector`. `ack_kind` is 0 in every cycle that does not follow an acknowledge.
- R8: `eoi_pulse` clears the highest in-service bit. If that vector is level-triggered and `eoi_suppress` is 0, `bcast_valid` pulses for one cycle, one cycle after the strobe, with the vector on `bcast_vector`.
- R9: `eoi_pulse` with an empty in-service map changes nothing and produces no broadcast.
- R10: `irq_pending` is registered. In each cycle it shows whether, on the previous cycle's state, the block was enabled and had an unmasked requested vector.
- R11: When a set and a granted acknowledge target the same vector in the same cycle, the acknowledge wins and the vector ends up not requested.
- R12: An acknowledge with no requested vector returns `ack_kind`=0 and `ack_vector`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Request a vector this cycle |
| set_vector | input | 8 | Vector to request |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| sw_enable | input | 1 | Software enable for delivery |
| eoi_suppress | input | 1 | 1 = never broadcast at end of interrupt |
| spurious_vector | input | 8 | Vector returned for a masked acknowledge |
| ack_req | input | 1 | Acknowledge strobe from the core |
| ack_kind | output | 2 | 0 none, 1 vector granted, 2 spurious |
| ack_vector | output | 8 | Granted or spurious vector |
| eoi_pulse | input | 1 | End-of-interrupt strobe |
| bcast_valid | output | 1 | Level end-of-interrupt broadcast pulse |
| bcast_vector | output | 8 | Vector being broadcast |
| irq_pending | output | 1 | Registered deliverable-interrupt flag |
| ppr | output | 8 | Current processor priority |

## Verification
The assertions check, on every cycle, a set of relations between outputs and state. Acknowledge and broadcast results only follow their strobes. Nothing is pending or granted while the block is disabled. `ppr` never falls below the task priority. A granted vector's class is above the previous processor priority. A spurious result carries the configured vector. The assertions cannot show that the correct vector is chosen, that trigger kinds are recorded, or how same-cycle set, acknowledge and end-of-interrupt strobes are ordered. Only the bench's directed sequences and its randomized comparison against a behavioural model show those.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_VEC   = 256;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int CLASS_LSB = 4;
    localparam int CLASS_W   = VEC_W - CLASS_LSB;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [CLASS_W-1:0] class_t;

    typedef enum logic [1:0] {
        ACK_NONE     = 2'd0,
        ACK_VECTOR   = 2'd1,
        ACK_SPURIOUS = 2'd2
    } ack_kind_e;

    // Result of a highest-bit search
    typedef struct packed {
        logic found;
        vec_t vec;
    } hit_t;

    // Registered acknowledge reply
    typedef struct packed {
        ack_kind_e kind;
        vec_t      vec;
    } ack_reply_t;

    // Registered broadcast event
    typedef struct packed {
        logic valid;
        vec_t vec;
    } vec_evt_t;

    function automatic class_t class_of(vec_t v);
        return v[VEC_W-1:CLASS_LSB];
    endfunction
endpackage

// File: rtl/irq_top_finder.sv
module irq_top_finder
    import irq_prio_pkg::*;
#(
    parameter int WIDTH  = NUM_VEC,
    parameter int WORD_W = 32
) (
    input  logic [WIDTH-1:0] bits,
    output hit_t             hit
);
    localparam int NWORDS = WIDTH / WORD_W;
    localparam int IW     = $clog2(WORD_W);
    localparam int WIW    = $clog2(NWORDS);

    logic [NWORDS-1:0] word_any;
    logic [IW-1:0]     word_idx [NWORDS];

    // First level: highest set bit inside each word
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic          any_l;
        logic [IW-1:0] idx_l;
        always_comb begin
            any_l = |bits[w*WORD_W +: WORD_W];
            idx_l = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) idx_l = IW'(b);
            end
        end
        assign word_any[w] = any_l;
        assign word_idx[w] = idx_l;
    end

    // Second level: highest word that holds any bit
    always_comb begin
        hit = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) begin
                hit.found = 1'b1;
                hit.vec   = {WIW'(w), word_idx[w]};
            end
        end
    end
endmodule

// File: rtl/irq_accept_eval.sv
module irq_accept_eval
    import irq_prio_pkg::*;
(
    input  vec_t   tpr,
    input  logic   isr_found,
    input  class_t isr_class,
    input  logic   irr_found,
    input  class_t irr_class,
    input  logic   enable,
    output vec_t   ppr,
    output logic   masked,
    output logic   deliverable
);
    class_t svc_class;

    always_comb begin
        svc_class   = isr_found ? isr_class : '0;
        ppr         = (class_of(tpr) >= svc_class) ? tpr : {svc_class, {CLASS_LSB{1'b0}}};
        masked      = irr_found && (ppr != '0) && (irr_class <= class_of(ppr));
        deliverable = enable && irr_found && !masked;
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_valid,
    input  logic [VEC_W-1:0] set_vector,
    input  logic             set_level,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             sw_enable,
    input  logic             eoi_suppress,
    input  logic [VEC_W-1:0] spurious_vector,
    input  logic             ack_req,
    output logic [1:0]       ack_kind,
    output logic [VEC_W-1:0] ack_vector,
    input  logic             eoi_pulse,
    output logic             bcast_valid,
    output logic [VEC_W-1:0] bcast_vector,
    output logic             irq_pending,
    output logic [VEC_W-1:0] ppr
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
    logic [NUM_VEC-1:0] set_mask, ack_mask, eoi_mask;
    vec_t               tpr_q;
    hit_t               irr_top, isr_top;
    logic               masked, deliverable;
    logic               ack_take, eoi_take;
    ack_reply_t         ack_d, ack_q;
    vec_evt_t           bc_d, bc_q;
    logic               pend_q;

    irq_top_finder #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
        .bits(irr_q), .hit(irr_top)
    );

    irq_top_finder #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
        .bits(isr_q), .hit(isr_top)
    );

    irq_accept_eval u_eval (
        .tpr         (tpr_q),
        .isr_found   (isr_top.found),
        .isr_class   (class_of(isr_top.vec)),
        .irr_found   (irr_top.found),
        .irr_class   (class_of(irr_top.vec)),
        .enable      (sw_enable),
        .ppr         (ppr),
        .masked      (masked),
        .deliverable (deliverable)
    );

    always_comb begin
        ack_take = ack_req && deliverable;
        eoi_take = eoi_pulse && isr_top.found;
        set_mask = set_valid ? (NUM_VEC'(1) << set_vector)  : '0;
        ack_mask = ack_take  ? (NUM_VEC'(1) << irr_top.vec) : '0;
        eoi_mask = eoi_take  ? (NUM_VEC'(1) << isr_top.vec) : '0;

        // Acknowledge clear overrides a same-cycle set of the same vector
        irr_d = (irr_q | set_mask) & ~ack_mask;
        tmr_d = set_level ? (tmr_q | set_mask) : (tmr_q & ~set_mask);
        // Acknowledge set overrides a same-cycle retirement
        isr_d = (isr_q & ~eoi_mask) | ack_mask;

        ack_d = '{kind: ACK_NONE, vec: '0};
        if (ack_req && sw_enable && irr_top.found) begin
            if (masked) ack_d = '{kind: ACK_SPURIOUS, vec: spurious_vector};
            else        ack_d = '{kind: ACK_VECTOR,   vec: irr_top.vec};
        end

        bc_d = '{valid: 1'b0, vec: '0};
        if (eoi_take && tmr_q[isr_top.vec] && !eoi_suppress) begin
            bc_d = '{valid: 1'b1, vec: isr_top.vec};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            isr_q  <= '0;
            tmr_q  <= '0;
            tpr_q  <= '0;
            ack_q  <= '{kind: ACK_NONE, vec: '0};
            bc_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            irr_q  <= irr_d;
            isr_q  <= isr_d;
            tmr_q  <= tmr_d;
            if (tpr_we) tpr_q <= tpr_wdata;
            ack_q  <= ack_d;
            bc_q   <= bc_d;
            pend_q <= deliverable;
        end
    end

    assign ack_kind     = ack_q.kind;
    assign ack_vector   = ack_q.vec;
    assign bcast_valid  = bc_q.valid;
    assign bcast_vector = bc_q.vec;
    assign irq_pending  = pend_q;
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk
    import irq_prio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ack_req,
    input logic               eoi_pulse,
    input logic               sw_enable,
    input logic [VEC_W-1:0]   spurious_vector,
    input logic [1:0]         ack_kind,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               bcast_valid,
    input logic               irq_pending,
    input logic [VEC_W-1:0]   ppr,
    input logic [VEC_W-1:0]   tpr_q,
    input logic [NUM_VEC-1:0] irr_q
);
    p_ack_follows_req_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_kind != 2'd0) |-> $past(ack_req));

    p_kind_legal_r7: assert property (@(posedge clk) disable iff (rst)
        ack_kind != 2'd3);

    p_bcast_follows_eoi_r8: assert property (@(posedge clk) disable iff (rst)
        bcast_valid |-> $past(eoi_pulse));

    p_pend_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> $past(sw_enable));

    p_ack_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_kind != 2'd0) |-> $past(sw_enable));

    p_pend_needs_request_r10: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> $past(|irr_q));

    p_ppr_floor_r3: assert property (@(posedge clk) disable iff (rst)
        ppr >= tpr_q);

    p_grant_above_ppr_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_kind == 2'd1 && $past(ppr) != '0) |-> (ack_vector[7:4] > $past(ppr[7:4])));

    p_spurious_value_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_kind == 2'd2) |-> (ack_vector == $past(spurious_vector)));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .ack_req         (ack_req),
    .eoi_pulse       (eoi_pulse),
    .sw_enable       (sw_enable),
    .spurious_vector (spurious_vector),
    .ack_kind        (ack_kind),
    .ack_vector      (ack_vector),
    .bcast_valid     (bcast_valid),
    .irq_pending     (irq_pending),
    .ppr             (ppr),
    .tpr_q           (tpr_q),
    .irr_q           (irr_q)
);

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_valid = 0, set_level = 0, tpr_we = 0;
    logic [7:0] set_vector = 0, tpr_wdata = 0, spurious_vector = 8'hFF;
    logic       sw_enable = 1, eoi_suppress = 0, ack_req = 0, eoi_pulse = 0;
    logic [1:0] ack_kind;
    logic [7:0] ack_vector, bcast_vector, ppr;
    logic       bcast_valid, irq_pending;

    always #4 clk = ~clk;

    irq_prio_arbiter uut (.*);

    int checks = 0, failures = 0;

    // Behavioural reference state
    bit m_irr[256], m_isr[256], m_tmr[256];
    int m_tpr = 0;
    int e_kind = 0, e_vec = 0, e_bv = 0, e_bvec = 0, e_pend = 0;

    function automatic int top_of(input bit a[256]);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return -1;
    endfunction

    function automatic int ppr_m();
        int hi = top_of(m_isr);
        int ic = (hi < 0) ? 0 : hi / 16;
        return ((m_tpr / 16) >= ic) ? m_tpr : ic * 16;
    endfunction

    function automatic bit blocked_m(int v, int p);
        return (p != 0) && ((v / 16) <= (p / 16));
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int h  = top_of(m_irr);
        int hi = top_of(m_isr);
        int p  = ppr_m();
        int av = -1;
        if (rst) begin
            for (int i = 0; i < 256; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
            m_tpr = 0; e_kind = 0; e_vec = 0; e_bv = 0; e_bvec = 0; e_pend = 0;
            return;
        end
        e_pend = (sw_enable && h >= 0 && !blocked_m(h, p)) ? 1 : 0;
        e_kind = 0; e_vec = 0;
        if (ack_req && sw_enable && h >= 0) begin
            if (blocked_m(h, p)) begin e_kind = 2; e_vec = spurious_vector; end
            else begin e_kind = 1; e_vec = h; av = h; end
        end
        e_bv = 0; e_bvec = 0;
        if (eoi_pulse && hi >= 0) begin
            if (m_tmr[hi] && !eoi_suppress) begin e_bv = 1; e_bvec = hi; end
            m_isr[hi] = 0;
        end
        if (set_valid) begin m_irr[set_vector] = 1; m_tmr[set_vector] = set_level; end
        if (av >= 0) begin m_irr[av] = 0; m_isr[av] = 1; end
        if (tpr_we) m_tpr = tpr_wdata;
    endtask

    task automatic compare_all();
        check("R10 pending", irq_pending, e_pend);
        check("R7 ack kind", ack_kind, e_kind);
        check("R7 ack vector", ack_vector, e_vec);
        check("R8 bcast valid", bcast_valid, e_bv);
        check("R8 bcast vector", bcast_vector, e_bvec);
        check("R3 ppr", ppr, ppr_m());
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #2;
        compare_all();
    endtask

    task automatic do_set(int v, bit lvl);
        set_valid = 1; set_vector = 8'(v); set_level = lvl; cyc(); set_valid = 0;
    endtask
    task automatic do_ack();  ack_req = 1;   cyc(); ack_req = 0;   endtask
    task automatic do_eoi();  eoi_pulse = 1; cyc(); eoi_pulse = 0; endtask
    task automatic do_tpr(int v); tpr_we = 1; tpr_wdata = 8'(v); cyc(); tpr_we = 0; endtask

    initial begin
        #(8 * 200000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 0;
        check("R1 reset pending", irq_pending, 0);
        check("R1 reset ack kind", ack_kind, 0);
        check("R1 reset bcast", bcast_valid, 0);
        check("R1 reset ppr", ppr, 0);

        do_set(8'h45, 1); do_set(8'h32, 0);
        do_ack();
        check("R4 highest kind", ack_kind, 1);
        check("R4 highest vector", ack_vector, 8'h45);
        check("R3 ppr from service", ppr, 8'h40);
        do_ack();
        check("R5 masked kind", ack_kind, 2);
        check("R5 masked vector", ack_vector, 8'hFF);
        do_eoi();
        check("R8 level bcast valid", bcast_valid, 1);
        check("R8 level bcast vector", bcast_vector, 8'h45);
        check("R3 ppr after retire", ppr, 0);
        do_ack();
        check("R7 grant vector", ack_vector, 8'h32);
        do_eoi();
        check("R2 edge no bcast", bcast_valid, 0);
        do_eoi();
        check("R9 empty eoi bcast", bcast_valid, 0);
        check("R9 empty eoi ppr", ppr, 0);
        do_ack();
        check("R12 empty ack kind", ack_kind, 0);
        check("R12 empty ack vector", ack_vector, 0);

        do_tpr(8'h50); do_set(8'h55, 0); cyc();
        check("R5 equal class pending", irq_pending, 0);
        do_set(8'h61, 0); cyc();
        check("R10 pending raised", irq_pending, 1);
        sw_enable = 0; cyc();
        check("R6 disabled pending", irq_pending, 0);
        do_ack();
        check("R6 disabled ack", ack_kind, 0);
        sw_enable = 1;

        set_valid = 1; set_vector = 8'h61; set_level = 0; ack_req = 1;
        cyc();
        set_valid = 0; ack_req = 0;
        check("R11 collide grant", ack_vector, 8'h61);
        do_eoi(); do_tpr(0);
        do_ack();
        check("R11 set lost kind", ack_kind, 1);
        check("R11 set lost vector", ack_vector, 8'h55);
        do_eoi();

        do_set(8'h70, 1); do_ack();
        eoi_suppress = 1; do_eoi();
        check("R8 suppressed bcast", bcast_valid, 0);
        eoi_suppress = 0;

        for (int n = 0; n < 4000; n++) begin
            set_valid  = ($urandom_range(0, 99) < 40);
            set_vector = 8'($urandom_range(0, 255));
            set_level  = 1'($urandom_range(0, 1));
            ack_req    = ($urandom_range(0, 99) < 30);
            eoi_pulse  = ($urandom_range(0, 99) < 25);
            tpr_we     = ($urandom_range(0, 99) < 5);
            tpr_wdata  = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 99) < 3) sw_enable = ~sw_enable;
            if ($urandom_range(0, 99) < 3) eoi_suppress = ~eoi_suppress;
            if ($urandom_range(0, 99) < 2) spurious_vector = 8'($urandom_range(0, 255));
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule